// File: doc/BRIEF.md
# Serial ADC Host Controller

This block drives one single-ended conversion at a time on an eight-channel, twelve-bit serial converter that runs its own conversion clock. A local requester pulses `start_i` with a channel number, a range bit, a polarity bit, two power-down bits and two framing choices. The controller lowers chip select and shifts out an eight-bit command that opens with a start bit. It then stops its serial clock, held low, while the converter is busy. After that it clocks in the twelve result bits and returns them with a one-cycle `done_o` pulse and the channel they belong to.

The end of the busy interval is found in one of two ways. In strobe mode the controller waits for the converter's busy strobe to rise again, and gives up with `err_o` if that takes longer than a set limit. In timed mode it ignores the strobe and waits a fixed number of system cycles. The data phase is either twelve clocks, which makes a twenty-clock frame, or sixteen clocks, which keeps the data phase byte-aligned. In the longer phase the four extra bits are zero fill. The serial clock comes from the system clock through a divider, so one serial period is `2*HALF` system cycles.

Top module: `adc_seq_host`

## Requirements
- R1: After chip select falls, the eight bits on `adc_din` at the first eight rising `adc_sclk` edges are, in time order: 1, `chan_i[2]`, `chan_i[1]`, `chan_i[0]`, `rng_i`, `bip_i`, `pd_i[1]`, `pd_i[0]`, using the values captured with `start_i`.
- R2: `adc_din` changes only while `adc_sclk` is low; it holds its value through every rising edge and high phase.
- R3: In strobe mode, `adc_sclk` stays low from the eighth falling edge until after `adc_sstrb` has gone low and then high again.
- R4: A completed frame gives `done_o` high for exactly one cycle. In that cycle `result_o` holds the twelve bits sampled on the first twelve data-phase rising edges, first bit in bit 11, and `chan_o` holds the requested channel.
- R5: A completed frame has 20 rising `adc_sclk` edges when `pad_i` was 0 and 24 when it was 1.
- R6: In strobe mode, if no strobe rise is seen within `TIMEOUT_CYC` cycles of the eighth falling edge, chip select rises exactly `TIMEOUT_CYC` cycles after that edge. `err_o` pulses in the same cycle, `done_o` does not pulse, and the controller goes back to idle.
- R7: In timed mode the strobe is ignored, and the first data-phase rising edge comes exactly `WAIT_CYC + HALF` cycles after the eighth falling edge.
- R8: `busy_o` is high from the cycle after an accepted start until the controller is idle again. A `start_i` pulse while busy starts no frame and changes neither the captured settings nor the result.
- R9: Chip select stays high for at least `2*HALF` cycles between frames.
- R10: During reset, `adc_cs_n` is 1 and `adc_sclk`, `adc_din`, `busy_o`, `done_o` and `err_o` are 0.
- R11: While shifting, each high phase of `adc_sclk` lasts exactly `HALF` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a conversion (one cycle, accepted only when idle) |
| chan_i | input | 3 | Channel to convert |
| rng_i | input | 1 | Range selection bit sent in the command |
| bip_i | input | 1 | Polarity selection bit sent in the command |
| pd_i | input | 2 | Power-down bits sent in the command |
| pad_i | input | 1 | 1: sixteen-clock data phase, 0: twelve-clock data phase |
| timed_i | input | 1 | 1: wait a fixed WAIT_CYC cycles, 0: wait for the strobe |
| busy_o | output | 1 | A frame or the inter-frame gap is in progress |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| err_o | output | 1 | One-cycle pulse when a strobe wait timed out |
| result_o | output | 12 | Converted value, valid with done_o |
| chan_o | output | 3 | Channel of result_o |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Command data to the converter |
| adc_dout | input | 1 | Result data from the converter |
| adc_sstrb | input | 1 | Converter busy strobe, low while converting |

## Verification
The checker assumes that the converter pulls its strobe low in the same instant as the eighth falling serial edge and keeps it low until the result is ready. It also assumes that result bits change only right after falling serial edges, and that in timed mode the result is ready before the fixed wait ends. The bench converter model keeps to these assumptions. It drops the strobe on the eighth falling edge and raises it after a drawn delay that is always shorter than the timeout (or never, in the one hang case), and shorter than `WAIT_CYC` in timed mode. It moves `adc_dout` only on falling edges and fills with zeros after the last bit.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CH_W  = 3;
  localparam int PD_W  = 2;
  localparam int CMD_W = 1 + CH_W + 2 + PD_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_CONV,
    ST_DATA,
    ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic            rng;
    logic            bip;
    logic [PD_W-1:0] pd;
    logic            pad;
    logic            timed;
  } req_cfg_t;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [W-1:0] LAST = W'(HALF - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = run && (cnt_q == LAST);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
    else         cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/adc_sync2.sv
module adc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      q    <= 1'b1;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end

endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
  import adc_seq_pkg::*;
#(
  parameter int HALF        = 2,
  parameter int RES_W       = 12,
  parameter int PAD_W       = 16,
  parameter int WAIT_CYC    = 300,
  parameter int TIMEOUT_CYC = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       chan_i,
  input  logic             rng_i,
  input  logic             bip_i,
  input  logic [1:0]       pd_i,
  input  logic             pad_i,
  input  logic             timed_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [RES_W-1:0] result_o,
  output logic [2:0]       chan_o,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_din,
  input  logic             adc_dout,
  input  logic             adc_sstrb
);

  localparam int CNT_W = $clog2(PAD_W + 1);
  localparam int TW    = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] RES_LAST  = CNT_W'(RES_W - 1);
  localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAD_W - 1);
  localparam logic [CNT_W-1:0] RES_CNT   = CNT_W'(RES_W);
  localparam logic [TW-1:0]    WAIT_LAST = TW'(WAIT_CYC - 1);
  localparam logic [TW-1:0]    TO_LAST   = TW'(TIMEOUT_CYC - 1);

  seq_state_e             state_q, state_d;
  req_cfg_t               cfg_q, cfg_d;
  logic                   cs_n_q, cs_n_d;
  logic                   sclk_q, sclk_d;
  logic                   din_q, din_d;
  logic [CMD_W-2:0]       cmd_q, cmd_d;
  logic [CNT_W-1:0]       bit_q, bit_d;
  logic [RES_W-1:0]       sh_q, sh_d;
  logic [RES_W-1:0]       res_q, res_d;
  logic                   done_q, done_d;
  logic                   err_q, err_d;
  logic                   strb_s, strb_q;

  logic                   tick, div_run, strb_rise, wait_done, timeout;
  logic [TW-1:0]          tcnt;

  assign div_run = (state_q == ST_CMD) || (state_q == ST_DATA) || (state_q == ST_GAP);

  adc_sclk_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(div_run), .tick(tick)
  );

  adc_wait_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != ST_CONV), .en(state_q == ST_CONV), .cnt(tcnt)
  );

  adc_sync2 u_sync (
    .clk(clk), .rst_n(rst_n), .d(adc_sstrb), .q(strb_s)
  );

  assign strb_rise = strb_s && !strb_q;
  assign wait_done = cfg_q.timed ? (tcnt == WAIT_LAST) : strb_rise;
  assign timeout   = !cfg_q.timed && (tcnt == TO_LAST);

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    cs_n_d  = cs_n_q;
    sclk_d  = sclk_q;
    din_d   = din_q;
    cmd_d   = cmd_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    res_d   = res_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cfg_d   = '{chan: chan_i, rng: rng_i, bip: bip_i, pd: pd_i,
                      pad: pad_i, timed: timed_i};
          cs_n_d  = 1'b0;
          din_d   = 1'b1;
          cmd_d   = {chan_i, rng_i, bip_i, pd_i};
          bit_d   = '0;
          state_d = ST_CMD;
        end
      end
      ST_CMD: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == CMD_LAST) begin
              din_d   = 1'b0;
              bit_d   = '0;
              state_d = ST_CONV;
            end else begin
              din_d = cmd_q[CMD_W-2];
              cmd_d = {cmd_q[CMD_W-3:0], 1'b0};
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      ST_CONV: begin
        if (wait_done) begin
          state_d = ST_DATA;
        end else if (timeout) begin
          cs_n_d  = 1'b1;
          err_d   = 1'b1;
          bit_d   = '0;
          state_d = ST_GAP;
        end
      end
      ST_DATA: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            if (bit_q < RES_CNT) sh_d = {sh_q[RES_W-2:0], adc_dout};
          end else begin
            sclk_d = 1'b0;
            if (bit_q == (cfg_q.pad ? PAD_LAST : RES_LAST)) begin
              cs_n_d  = 1'b1;
              done_d  = 1'b1;
              res_d   = sh_q;
              bit_d   = '0;
              state_d = ST_GAP;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          bit_d = bit_q + 1'b1;
          if (bit_q != '0) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      din_q   <= 1'b0;
      cmd_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      strb_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      din_q   <= din_d;
      cmd_q   <= cmd_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      res_q   <= res_d;
      done_q  <= done_d;
      err_q   <= err_d;
      strb_q  <= strb_s;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = res_q;
  assign chan_o   = cfg_q.chan;
  assign adc_cs_n = cs_n_q;
  assign adc_sclk = sclk_q;
  assign adc_din  = din_q;

endmodule

// File: rtl/adc_seq_host_chk.sv
module adc_seq_host_chk #(
  parameter int HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic adc_din,
  input logic adc_sstrb,
  input logic done_o,
  input logic err_o,
  input logic pad,
  input logic timed
);

  logic        cs_q, sclk_q, strb_lo, strb_done;
  logic [7:0]  rise_cnt;
  logic [15:0] hi_cnt, gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      sclk_q    <= 1'b0;
      rise_cnt  <= '0;
      hi_cnt    <= '0;
      gap_cnt   <= 16'hFFFF;
      strb_lo   <= 1'b0;
      strb_done <= 1'b0;
    end else begin
      cs_q   <= adc_cs_n;
      sclk_q <= adc_sclk;
      if (!adc_cs_n && cs_q) begin
        rise_cnt  <= '0;
        strb_lo   <= 1'b0;
        strb_done <= 1'b0;
      end else begin
        if (adc_sclk && !sclk_q) rise_cnt <= rise_cnt + 8'd1;
        if (!adc_cs_n && rise_cnt == 8'd8 && !adc_sstrb) strb_lo <= 1'b1;
        if (strb_lo && adc_sstrb) strb_done <= 1'b1;
      end
      hi_cnt <= adc_sclk ? hi_cnt + 16'd1 : 16'd0;
      if (!adc_cs_n)               gap_cnt <= '0;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
    end
  end

  // R2
  din_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> $stable(adc_din));

  // R3
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk && !sclk_q && rise_cnt == 8'd8 && !timed) |-> strb_done);

  // R5
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_cs_n && !cs_q) |-> (err_o ? (rise_cnt == 8'd8)
                                   : (rise_cnt == (pad ? 8'd24 : 8'd20))));

  // R11
  half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_sclk && sclk_q) |-> (hi_cnt == 16'(HALF)));

  // R9
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && cs_q) |-> (gap_cnt >= 16'(2 * HALF)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  err_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (adc_cs_n && !done_o));

endmodule

bind adc_seq_host adc_seq_host_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
  .adc_din(adc_din), .adc_sstrb(adc_sstrb), .done_o(done_o), .err_o(err_o),
  .pad(cfg_q.pad), .timed(cfg_q.timed)
);

// File: tb/adc_seq_host_test.sv
`timescale 1ns/1ps
module adc_seq_host_test;

  localparam int CLK_NS   = 10;
  localparam int HALF     = 2;
  localparam int WAIT_CYC = 300;
  localparam int TO_CYC   = 600;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  chan_i;
  logic        rng_i, bip_i, pad_i, timed_i;
  logic [1:0]  pd_i;
  logic        busy_o, done_o, err_o;
  logic [11:0] result_o;
  logic [2:0]  chan_o;
  logic        adc_cs_n, adc_sclk, adc_din;
  logic        adc_dout  = 1'b0;
  logic        adc_sstrb = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  adc_seq_host #(.HALF(HALF), .WAIT_CYC(WAIT_CYC), .TIMEOUT_CYC(TO_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .rng_i(rng_i), .bip_i(bip_i), .pd_i(pd_i), .pad_i(pad_i),
    .timed_i(timed_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .result_o(result_o), .chan_o(chan_o), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout(adc_dout),
    .adc_sstrb(adc_sstrb)
  );

  function automatic logic [11:0] conv_val(input logic [7:0] ctrl, input int seq);
    int v;
    v = (int'(ctrl) * 53) ^ (seq * 389) ^ 32'h5A3;
    return v[11:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int         m_seq, m_delay, m_frames, m_rise, m_total, m_rise_conv;
  bit         m_hang, m_started;
  int         m_phase;            // 0 command, 1 converting, 2 data
  logic [7:0] m_ctrl;
  logic [11:0] m_sh;
  time        t_fall8, t_strb, t_data1, t_csrise, t_csrise_prev;
  int         min_gap = 1000000;
  event       conv_ev;

  always @(negedge adc_cs_n) begin
    m_frames++;
    m_rise = 0; m_total = 0; m_started = 0; m_phase = 0; m_ctrl = 0;
    t_data1 = 0;
    if (t_csrise != 0 && (($time - t_csrise) / CLK_NS) < min_gap)
      min_gap = int'(($time - t_csrise) / CLK_NS);
  end

  always @(posedge adc_cs_n) begin
    t_csrise  = $time;
    adc_sstrb = 1'b1;
    adc_dout  = 1'b0;
    m_phase   = 3;
  end

  always @(posedge adc_sclk) begin
    if (!adc_cs_n) begin
      m_total++;
      if (m_phase == 0) begin
        if (!m_started) begin
          if (adc_din) begin m_started = 1; m_ctrl = 8'h01; m_rise = 1; end
        end else begin
          m_ctrl = {m_ctrl[6:0], adc_din};
          m_rise++;
        end
      end else if (m_phase == 1) begin
        m_rise_conv++;
      end else if (m_phase == 2 && t_data1 == 0) begin
        t_data1 = $time;
      end
    end
  end

  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      if (m_phase == 0 && m_rise == 8) begin
        m_phase   = 1;
        adc_sstrb = 1'b0;
        t_fall8   = $time;
        -> conv_ev;
      end else if (m_phase == 2) begin
        m_sh     = {m_sh[10:0], 1'b0};
        adc_dout = m_sh[11];
      end
    end
  end

  always begin
    @(conv_ev);
    if (!m_hang) begin
      repeat (m_delay) @(posedge clk);
      #1;
      if (!adc_cs_n && m_phase == 1) begin
        m_sh      = conv_val(m_ctrl, m_seq);
        adc_dout  = m_sh[11];
        adc_sstrb = 1'b1;
        t_strb    = $time;
        m_phase   = 2;
      end
    end
  end

  // -------------- port-level timing monitors --------------
  int   din_bad = 0, half_bad = 0, hi_len = 0;
  logic prev_din = 1'b0, prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_sclk && adc_din !== prev_din) din_bad++;
      if (adc_sclk) hi_len++;
      else begin
        if (prev_sclk && hi_len != HALF) half_bad++;
        hi_len = 0;
      end
    end
    prev_din  = adc_din;
    prev_sclk = adc_sclk;
  end

  // ---------------- one conversion ----------------
  task automatic run_conv(input logic [2:0] ch, input logic r, input logic b,
                          input logic [1:0] pd, input logic pad, input logic timed,
                          input int dly, input bit hang, input bit extra_start);
    logic [7:0] ectrl;
    int f0, k;
    bit gd, ge;
    logic [11:0] gres;
    logic [2:0]  gch;
    ectrl = {1'b1, ch, r, b, pd};
    m_seq++;
    m_delay = dly; m_hang = hang; m_rise_conv = 0;
    f0 = m_frames;
    @(negedge clk);
    chan_i = ch; rng_i = r; bip_i = b; pd_i = pd; pad_i = pad; timed_i = timed;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chan_i = ~ch; rng_i = ~r; bip_i = ~b; pd_i = ~pd;
    chk("R8 busy after accepted start", busy_o, 1);
    if (extra_start) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1; chan_i = ch + 3'd3; pad_i = ~pad; timed_i = ~timed;
      @(negedge clk);
      start_i = 1'b0;
    end
    k = 0;
    while (!(done_o || err_o) && k < 5000) begin @(negedge clk); k++; end
    gd = done_o; ge = err_o; gres = result_o; gch = chan_o;
    if (hang) begin
      chk("R6 error pulse on timeout", ge, 1);
      chk("R6 no done on timeout", gd, 0);
      chk("R6 timeout cycles", int'((t_csrise - t_fall8) / CLK_NS), TO_CYC);
      chk("R6 cs high after timeout", adc_cs_n, 1);
    end else begin
      chk("R4 done seen", gd, 1);
      chk("R4 result", gres, conv_val(ectrl, m_seq));
      chk("R4 channel", gch, ch);
      chk("R1 control byte", m_ctrl, ectrl);
      chk("R5 rising edges per frame", m_total, pad ? 24 : 20);
      chk("R3 no clocks during conversion", m_rise_conv, 0);
      if (timed)
        chk("R7 timed wait length", int'((t_data1 - t_fall8) / CLK_NS), WAIT_CYC + HALF);
      else
        chk("R3 data after strobe", (t_data1 > t_strb), 1);
    end
    @(negedge clk);
    chk("R4 done one cycle", done_o, 0);
    k = 0;
    while (busy_o && k < 5000) begin @(negedge clk); k++; end
    chk("R8 one frame per accepted start", m_frames - f0, 1);
    chk("R8 idle after frame", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd1234);
    rst_n = 1'b0; start_i = 1'b0; chan_i = 0; rng_i = 0; bip_i = 0;
    pd_i = 0; pad_i = 0; timed_i = 0;
    m_seq = 0; m_frames = 0; t_csrise = 0;
    repeat (4) @(negedge clk);
    chk("R10 cs_n in reset", adc_cs_n, 1);
    chk("R10 sclk in reset", adc_sclk, 0);
    chk("R10 din in reset", adc_din, 0);
    chk("R10 busy in reset", busy_o, 0);
    chk("R10 done/err in reset", {done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_conv(3'd7, 1, 1, 2'b11, 0, 0, 40, 0, 0);
    run_conv(3'd0, 0, 0, 2'b00, 0, 0, 1, 0, 0);
    run_conv(3'd5, 1, 0, 2'b10, 1, 0, 120, 0, 0);
    run_conv(3'd2, 0, 1, 2'b01, 0, 1, 5, 0, 0);
    run_conv(3'd6, 1, 1, 2'b11, 1, 1, 250, 0, 0);
    run_conv(3'd4, 0, 1, 2'b11, 0, 0, 0, 1, 0);
    run_conv(3'd1, 1, 0, 2'b01, 0, 0, 30, 0, 1);
    run_conv(3'd3, 0, 0, 2'b10, 0, 0, TO_CYC - 20, 0, 0);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      logic [2:0] ch;
      logic [1:0] pd;
      logic r, b, pad, tm;
      int dly;
      ch  = 3'($urandom_range(0, 7));
      pd  = 2'($urandom_range(0, 3));
      r   = 1'($urandom_range(0, 1));
      b   = 1'($urandom_range(0, 1));
      pad = 1'($urandom_range(0, 1));
      tm  = ($urandom_range(0, 4) == 0);
      dly = int'($urandom_range(1, 280));
      run_conv(ch, r, b, pd, pad, tm, dly, 0, (i % 7) == 3);
    end

    chk("R2 din stable while sclk high", din_bad, 0);
    chk("R11 sclk high phase length", half_bad, 0);
    chk("R9 minimum cs high gap", (min_gap >= 2 * HALF), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule